// File: doc/BRIEF.md
# Synchronous Peripheral Bus Slave Interface

This block is the host-facing port of an oscillator card on an 8-bit processor bus. That bus uses an enable clock together with a valid-memory-address strobe and a valid-peripheral-address handshake. The block compares the upper address lines and three qualifying strobes (data strobe, address strobe, I/O qualifier) against a pattern set by parameters.

On a match, the block pulls its peripheral-address handshake low. The same low level opens the card's data buffers. The host answers by aligning its valid-memory-address strobe to the enable clock. Data then moves only inside that strobe's low window.

Writes land in a command register or a data register. Reads return an external status byte, the data register, or either byte of a phase word that is latched on a capture pulse. Every bus input is sampled on the card's own clock, so each rule below is counted in cycles of `clk`.

Top module: `spb_slave`

## Requirements
- R1: After reset, `vpa_n` is 1, `buf_en` is 0, `dout_oe` is 0, and `cmd_q`, `data_q` and the latched phase all read 0.
- R2: When `a_hi` equals `MATCH_ADDR` and `ds_n`, `as_n` and `io_n` equal their parameter levels (0 by default) in one cycle, `vpa_n` is 0 and `buf_en` is 1 in the next cycle.
- R3: If any one of the four qualifiers fails to match, `vpa_n` returns to 1 in the next cycle.
- R4: A write happens on the `clk` edge where `e_clk` is seen falling (it was 1 in the previous cycle and is 0 now). At that edge `vma_n` must be 0, the address must match, `vpa_n` must be 0 and `rd_wr` must be 0. Select 0 writes `cmd_q` and select 1 writes `data_q`. The new value is visible after that edge.
- R5: A falling `e_clk` with `vma_n` at 1 writes nothing.
- R6: A falling `e_clk` while the address does not match, or while `vpa_n` is still 1, writes nothing.
- R7: `dout_oe` is 1 only while `e_clk` is 1, `vma_n` is 0, the address matches, `vpa_n` is 0 and `rd_wr` is 1. In all other cases the bus is released.
- R8: During a read, `dout` returns the data for the select value: 0 gives `status_in`, 1 gives `data_q`, 2 gives the low byte of the latched phase, and 3 gives its high byte.
- R9: A pulse on `phase_cap` latches `phase_in`, and the latched value can be read from the next cycle on.
- R10: A falling `e_clk` during a read cycle (`rd_wr` = 1) leaves `cmd_q` and `data_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_hi | input | 5 | Upper address lines compared with the window pattern |
| a_sel | input | 2 | Low address lines choosing the register |
| ds_n | input | 1 | Data strobe qualifier |
| as_n | input | 1 | Address strobe qualifier |
| io_n | input | 1 | I/O space qualifier |
| vma_n | input | 1 | Host valid-memory-address strobe, active low |
| e_clk | input | 1 | Host enable clock, sampled |
| rd_wr | input | 1 | 1 = read, 0 = write |
| din | input | 8 | Write data from the bus |
| status_in | input | 8 | Status byte returned at select 0 |
| phase_in | input | 16 | Phase word to be latched |
| phase_cap | input | 1 | Capture pulse for the phase latch |
| vpa_n | output | 1 | Valid-peripheral-address handshake, active low |
| buf_en | output | 1 | Data buffer enable |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| cmd_q | output | 8 | Command register |
| data_q | output | 8 | Data register |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit register select, window pattern 5'h13, and all three strobe levels active-low. With these values, each qualifier can be flipped on its own to show that any single mismatch releases the handshake. All four read selects can be reached, and both bytes of the 16-bit phase latch can be read back. Write tests are repeated with the strobe high, with the address missing, and in read mode, and each time the registers are read back to show they kept their values.

// File: rtl/spb_pkg.sv
package spb_pkg;
  function automatic logic addr_ok(
    input logic [4:0] a, input logic [4:0] pat,
    input logic ds, input logic ds_lvl,
    input logic as_i, input logic as_lvl,
    input logic io, input logic io_lvl);
    return (a == pat) && (ds == ds_lvl) && (as_i == as_lvl) && (io == io_lvl);
  endfunction

  function automatic logic e_fell(input logic prev, input logic now);
    return prev & ~now;
  endfunction
endpackage

// File: rtl/spb_addr_match.sv
module spb_addr_match #(
  parameter int AW = 5,
  parameter logic [AW-1:0] MATCH_ADDR = 5'h13,
  parameter logic DS_LVL = 1'b0,
  parameter logic AS_LVL = 1'b0,
  parameter logic IO_LVL = 1'b0
) (
  input  logic [AW-1:0] a_hi,
  input  logic          ds_n,
  input  logic          as_n,
  input  logic          io_n,
  output logic          hit
);
  import spb_pkg::*;
  always_comb hit = addr_ok(a_hi, MATCH_ADDR, ds_n, DS_LVL, as_n, AS_LVL, io_n, IO_LVL);
endmodule

// File: rtl/spb_xfer_ctl.sv
module spb_xfer_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic vma_n,
  input  logic e_clk,
  input  logic rd_wr,
  output logic vpa_n,
  output logic wr_stb,
  output logic rd_oe
);
  import spb_pkg::*;
  logic e_q;
  logic window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpa_n <= 1'b1;
      e_q   <= 1'b0;
    end else begin
      vpa_n <= ~hit;
      e_q   <= e_clk;
    end
  end

  always_comb begin
    window = hit & ~vpa_n & ~vma_n;
    wr_stb = window & ~rd_wr & e_fell(e_q, e_clk);
    rd_oe  = window & rd_wr & e_clk;
  end
endmodule

// File: rtl/spb_regs.sv
module spb_regs #(
  parameter int DW = 8,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] status_in,
  input  logic [2*DW-1:0] phase_in,
  input  logic          phase_cap,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] rdata
);
  localparam int PW = 2 * DW;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      data_q  <= '0;
      phase_q <= '0;
    end else begin
      if (wr_stb && sel == SW'(0)) cmd_q  <= din;
      if (wr_stb && sel == SW'(1)) data_q <= din;
      if (phase_cap) phase_q <= phase_in;
    end
  end

  always_comb begin
    unique case (sel)
      SW'(0):  rdata = status_in;
      SW'(1):  rdata = data_q;
      SW'(2):  rdata = phase_q[DW-1:0];
      default: rdata = phase_q[PW-1:DW];
    endcase
  end
endmodule

// File: rtl/spb_slave.sv
module spb_slave #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int AHI_W  = 5,
  parameter logic [AHI_W-1:0] MATCH_ADDR = 5'h13,
  parameter logic DS_LVL = 1'b0,
  parameter logic AS_LVL = 1'b0,
  parameter logic IO_LVL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AHI_W-1:0]    a_hi,
  input  logic [SEL_W-1:0]    a_sel,
  input  logic                ds_n,
  input  logic                as_n,
  input  logic                io_n,
  input  logic                vma_n,
  input  logic                e_clk,
  input  logic                rd_wr,
  input  logic [DATA_W-1:0]   din,
  input  logic [DATA_W-1:0]   status_in,
  input  logic [2*DATA_W-1:0] phase_in,
  input  logic                phase_cap,
  output logic                vpa_n,
  output logic                buf_en,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_oe,
  output logic [DATA_W-1:0]   cmd_q,
  output logic [DATA_W-1:0]   data_q
);
  logic hit;
  logic wr_stb;
  logic [DATA_W-1:0] rdata;

  spb_addr_match #(.AW(AHI_W), .MATCH_ADDR(MATCH_ADDR), .DS_LVL(DS_LVL),
                   .AS_LVL(AS_LVL), .IO_LVL(IO_LVL)) u_match (
    .a_hi(a_hi), .ds_n(ds_n), .as_n(as_n), .io_n(io_n), .hit(hit));

  spb_xfer_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .hit(hit), .vma_n(vma_n), .e_clk(e_clk),
    .rd_wr(rd_wr), .vpa_n(vpa_n), .wr_stb(wr_stb), .rd_oe(dout_oe));

  spb_regs #(.DW(DATA_W), .SW(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel(a_sel), .din(din),
    .status_in(status_in), .phase_in(phase_in), .phase_cap(phase_cap),
    .cmd_q(cmd_q), .data_q(data_q), .rdata(rdata));

  assign buf_en = ~vpa_n;
  assign dout   = dout_oe ? rdata : '0;
endmodule

// File: rtl/spb_slave_chk.sv
module spb_slave_chk #(parameter int DATA_W = 8) (
  input logic clk,
  input logic rst_n,
  input logic hit,
  input logic wr_stb,
  input logic vpa_n,
  input logic buf_en,
  input logic vma_n,
  input logic e_clk,
  input logic rd_wr,
  input logic dout_oe,
  input logic [DATA_W-1:0] cmd_q,
  input logic [DATA_W-1:0] data_q
);
  assert_vpa_assert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (!vpa_n && buf_en));
  assert_vpa_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> vpa_n);
  assert_no_write_vma_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vma_n |=> ($stable(cmd_q) && $stable(data_q)));
  assert_no_write_unmatched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || vpa_n) |=> ($stable(cmd_q) && $stable(data_q)));
  assert_oe_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (e_clk && !vma_n && !vpa_n && rd_wr && hit));
  assert_no_write_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr |=> ($stable(cmd_q) && $stable(data_q)));
  assert_regs_need_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(cmd_q) && $stable(data_q)));
endmodule

bind spb_slave spb_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .wr_stb(wr_stb), .vpa_n(vpa_n),
  .buf_en(buf_en), .vma_n(vma_n), .e_clk(e_clk), .rd_wr(rd_wr),
  .dout_oe(dout_oe), .cmd_q(cmd_q), .data_q(data_q));

// File: tb/spb_slave_test.sv
module spb_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] a_hi = 5'h00;
  logic [1:0] a_sel = 2'd0;
  logic ds_n = 1'b1, as_n = 1'b1, io_n = 1'b1, vma_n = 1'b1, e_clk = 1'b0, rd_wr = 1'b1;
  logic [7:0] din = 8'h00, status_in = 8'h5A;
  logic [15:0] phase_in = 16'h0000;
  logic phase_cap = 1'b0;
  logic vpa_n, buf_en, dout_oe;
  logic [7:0] dout, cmd_q, data_q;

  localparam logic [4:0] WIN = 5'h13;

  spb_slave uut (.*);

  always #5 clk = ~clk;

  typedef struct { string req; logic [15:0] exp; } item_t;
  item_t sbq[$];
  int checks = 0;
  int errors = 0;

  task automatic expect_val(input string req, input logic [15:0] v);
    item_t it;
    it.req = req; it.exp = v;
    sbq.push_back(it);
  endtask

  task automatic observe(input logic [15:0] act);
    item_t it;
    checks++;
    if (sbq.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty act=%h exp=none", act);
    end else begin
      it = sbq.pop_front();
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.req, act, it.exp);
      end
    end
  endtask

  task automatic idle_bus();
    @(negedge clk);
    a_hi = 5'h00; ds_n = 1; as_n = 1; io_n = 1; vma_n = 1; e_clk = 0; rd_wr = 1;
    repeat (2) @(posedge clk);
  endtask

  task automatic set_match(input bit m);
    a_hi = m ? WIN : 5'h00; ds_n = 0; as_n = 0; io_n = 0;
  endtask

  // Write cycle: e high, wait for handshake, then drop e
  task automatic bus_write(input logic [1:0] s, input logic [7:0] v, input bit vma_lo, input bit m);
    @(negedge clk);
    set_match(m); a_sel = s; din = v; rd_wr = 0; vma_n = ~vma_lo; e_clk = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    e_clk = 0;
    @(posedge clk);
    idle_bus();
  endtask

  task automatic bus_read(input logic [1:0] s, input string req, input logic [7:0] v);
    @(negedge clk);
    set_match(1); a_sel = s; rd_wr = 1; vma_n = 0; e_clk = 1;
    repeat (2) @(posedge clk);
    #2;
    expect_val({req, " oe"}, 16'h1); observe({15'd0, dout_oe});
    expect_val({req, " data"}, {8'h00, v}); observe({8'h00, dout});
    @(negedge clk);
    e_clk = 0;
    #2;
    expect_val("R7 oe off with e low", 16'h0); observe({15'd0, dout_oe});
    idle_bus();
  endtask

  // single-qualifier mismatch: 0 a_hi, 1 ds, 2 as, 3 io
  task automatic mismatch(input int which);
    @(negedge clk);
    set_match(1);
    @(posedge clk); #2;
    expect_val("R2 vpa low on match", 16'h0); observe({15'd0, vpa_n});
    expect_val("R2 buf_en on match", 16'h1); observe({15'd0, buf_en});
    @(negedge clk);
    case (which)
      0: a_hi = WIN ^ 5'h04;
      1: ds_n = 1;
      2: as_n = 1;
      default: io_n = 1;
    endcase
    @(posedge clk); #2;
    expect_val($sformatf("R3 release on mismatch %0d", which), 16'h1); observe({15'd0, vpa_n});
    idle_bus();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    expect_val("R1 vpa_n", 16'h1); observe({15'd0, vpa_n});
    expect_val("R1 buf_en", 16'h0); observe({15'd0, buf_en});
    expect_val("R1 oe", 16'h0); observe({15'd0, dout_oe});
    expect_val("R1 cmd", 16'h0); observe({8'h0, cmd_q});
    expect_val("R1 data", 16'h0); observe({8'h0, data_q});
    @(negedge clk); rst_n = 1;
    idle_bus();
    bus_read(2'd2, "R1 phase lo", 8'h00);

    for (int w = 0; w < 4; w++) mismatch(w);

    bus_write(2'd0, 8'hA5, 1, 1); #2;
    expect_val("R4 cmd write", 16'h00A5); observe({8'h0, cmd_q});
    bus_write(2'd1, 8'h3C, 1, 1); #2;
    expect_val("R4 data write", 16'h003C); observe({8'h0, data_q});
    expect_val("R4 cmd untouched", 16'h00A5); observe({8'h0, cmd_q});

    bus_write(2'd0, 8'hFF, 0, 1); #2;
    expect_val("R5 vma high ignored", 16'h00A5); observe({8'h0, cmd_q});
    bus_write(2'd1, 8'h77, 0, 0); #2;
    expect_val("R6 unmatched ignored", 16'h003C); observe({8'h0, data_q});

    // R6: falling e before vpa asserted
    @(negedge clk);
    e_clk = 1; rd_wr = 0; a_sel = 2'd0; din = 8'h11; vma_n = 0;
    @(negedge clk);
    set_match(1); e_clk = 0;
    @(posedge clk); #2;
    expect_val("R6 vpa still high ignored", 16'h00A5); observe({8'h0, cmd_q});
    idle_bus();

    // R10: falling e during read
    @(negedge clk);
    set_match(1); a_sel = 2'd1; din = 8'h99; rd_wr = 1; vma_n = 0; e_clk = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); e_clk = 0;
    @(posedge clk); #2;
    expect_val("R10 read does not write", 16'h003C); observe({8'h0, data_q});
    idle_bus();

    // R7: oe off with vma high
    @(negedge clk);
    set_match(1); rd_wr = 1; vma_n = 1; e_clk = 1;
    repeat (2) @(posedge clk); #2;
    expect_val("R7 oe off vma high", 16'h0); observe({15'd0, dout_oe});
    idle_bus();

    // R9 phase capture
    @(negedge clk);
    phase_in = 16'hBEEF; phase_cap = 1;
    @(negedge clk);
    phase_cap = 0; phase_in = 16'h0000;
    bus_read(2'd0, "R8 status", 8'h5A);
    bus_read(2'd1, "R8 data reg", 8'h3C);
    bus_read(2'd2, "R9 phase lo", 8'hEF);
    bus_read(2'd3, "R9 phase hi", 8'hBE);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule